// File: doc/BRIEF.md
# Completion Status Ring Writer

This block produces completion messages into a circular ring of fixed-size entries held in local storage. Each accepted completion request becomes one 128-bit entry of four 32-bit words: the first word holds the descriptor count, the ring identifier, the outcome code and a phase flag. The others carry a timestamp, transmit details (rate index, queue, aggregate count, retry flag, antenna sector) and a sequence number. The ring holds `2**ORDER` entries, and the write position steps by one modulo that size.

A consumer does not read a producer index to find new work. It compares the phase flag of the entry at its tail with the phase it expects. The writer stores phase 1 on its first pass and inverts the stored value each time its position wraps to entry 0. The consumer inverts its expected phase each time its own tail wraps. An entry is written in a single wide write, so a consumer never sees a flagged entry that is only partly filled. When one more write would make the head reach the consumer tail, the writer holds off the request port. It never overwrites an entry the consumer has not released.

Top module: `status_ring_writer`

## Requirements
- R1: Word 0 (entry bits 31:0) holds the descriptor count in bits 7:0, the ring id in bits 15:8 and the outcome code in bits 23:16. Bits 30:24 are zero and bit 31 is the phase flag.
- R2: Word 1 (entry bits 63:32) is the timestamp. Word 2 (bits 95:64) has the rate index in bits 4:0, the queue id in bits 12:8, the aggregate count in bits 20:16, the retry flag in bit 23 and the sector in bits 31:24, with every other bit zero. Word 3 (bits 127:96) has the sequence number in bits 11:0 and zeros above.
- R3: Outcome codes 0 to 3 are written. A request with a code from 4 to 255 is accepted (it completes its handshake) but writes no entry and leaves the write position unchanged.
- R4: After reset every entry's phase flag reads 0, so `cons_new` is 0 and `req_ready` is 1.
- R5: On the first pass through the ring the writer stores phase 1. The stored value inverts each time the write position wraps from the last entry to entry 0.
- R6: The ring holds at most `2**ORDER - 1` unreleased entries. `req_ready` is 0 exactly when (head + 1) modulo the size equals the tail, and a request presented then is not taken.
- R7: In the cycle after an entry is accepted, all four of its words and its phase flag are visible together at the consumer port.
- R8: `cons_new` is 1 when the phase flag of the entry at the tail equals the expected phase. `cons_pop` advances the tail by one only while `cons_new` is 1 and is otherwise ignored. The expected phase inverts when the tail wraps to 0.
- R9: A synchronous reset sets the head and tail to 0 and sets the writer phase and the expected phase to 1.
- R10: Entries reach the consumer in the order their requests were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Completion request present |
| req_ready | output | 1 | Writer can take a request (ring not full) |
| req_ndesc | input | 8 | Descriptor count |
| req_ring | input | 8 | Ring identifier |
| req_code | input | 8 | Outcome code |
| req_tstamp | input | 32 | Timestamp |
| req_mcs | input | 5 | Rate index |
| req_qid | input | 5 | Queue identifier |
| req_nmsdu | input | 5 | Aggregate count |
| req_retry | input | 1 | Retry flag |
| req_sector | input | 8 | Antenna sector |
| req_seq | input | 12 | Sequence number |
| cons_pop | input | 1 | Release the entry at the tail |
| cons_new | output | 1 | Entry at the tail is new |
| cons_entry | output | 128 | Entry at the tail, word 0 in bits 31:0 |

## Verification
The ring is tried with a short burst that is drained at once, with a steady stream and no pops that fills it to the stall point, and with long mixed traffic that drives the head and tail through several wraps. The short burst separates the field layout from ordering. The fill shows whether capacity stops at one less than the ring size. The wraps show whether the writer phase and the consumer phase invert at the right entry. Reserved codes, pops on an empty ring and a reset with live entries are mixed in, so that dropped requests, ignored pops and cleared flags show at the ports.

// File: rtl/status_ring_writer.sv
module status_ring_writer #(
  parameter int ORDER = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [7:0]   req_ndesc,
  input  logic [7:0]   req_ring,
  input  logic [7:0]   req_code,
  input  logic [31:0]  req_tstamp,
  input  logic [4:0]   req_mcs,
  input  logic [4:0]   req_qid,
  input  logic [4:0]   req_nmsdu,
  input  logic         req_retry,
  input  logic [7:0]   req_sector,
  input  logic [11:0]  req_seq,
  input  logic         cons_pop,
  output logic         cons_new,
  output logic [127:0] cons_entry
);
  localparam int DEPTH = 1 << ORDER;
  localparam logic [ORDER-1:0] LAST = ORDER'(DEPTH - 1);
  localparam int CODE_LIMIT = 4;

  logic [ORDER-1:0] head, tail;
  logic             wr_phase, cons_phase;
  logic [DEPTH-1:0] flag;
  logic [126:0]     slot [DEPTH];

  logic [ORDER-1:0] head_nx;
  logic             accept, wr_en, pop_en;
  logic [126:0]     packed_in;
  logic [126:0]     tail_slot;

  assign head_nx   = head + 1'b1;
  assign req_ready = (head_nx != tail);
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && (int'(req_code) < CODE_LIMIT);
  assign cons_new  = (flag[tail] == cons_phase);
  assign pop_en    = cons_pop && cons_new;

  // words 3,2,1 then word 0 minus its phase bit
  assign packed_in = {
    20'd0, req_seq,
    req_sector, req_retry, 2'd0, req_nmsdu, 3'd0, req_qid, 3'd0, req_mcs,
    req_tstamp,
    7'd0, req_code, req_ring, req_ndesc
  };

  assign tail_slot  = slot[tail];
  assign cons_entry = {tail_slot[126:31], flag[tail], tail_slot[30:0]};

  always_ff @(posedge clk) begin
    if (wr_en) slot[head] <= packed_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head     <= '0;
      wr_phase <= 1'b1;
      flag     <= '0;
    end else if (wr_en) begin
      flag[head] <= wr_phase;
      head       <= head_nx;
      if (head == LAST) wr_phase <= ~wr_phase;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tail       <= '0;
      cons_phase <= 1'b1;
    end else if (pop_en) begin
      tail <= tail + 1'b1;
      if (tail == LAST) cons_phase <= ~cons_phase;
    end
  end

  logic armed, rst_q;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst && rst_q === 1'b1)
      p_reset_state_r9: assert (head == '0 && tail == '0 && wr_phase && cons_phase && !cons_new);
  end

  p_wrap_flip_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && wr_en && head == LAST) |=> (wr_phase != $past(wr_phase)));

  p_rsvd_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && accept && int'(req_code) >= CODE_LIMIT) |=> (head == $past(head)));

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && req_valid && !req_ready) |=> (head == $past(head)));

  p_pop_needs_new_r8: assert property (@(posedge clk) disable iff (rst)
    (armed && cons_pop && !cons_new) |=> (tail == $past(tail)));

  p_visible_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && wr_en) |=> (flag[$past(head)] == $past(wr_phase)));
endmodule

// File: tb/status_ring_writer_tb.sv
module status_ring_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ORD = 3;
  localparam int N = 1 << ORD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_retry = 1'b0, cons_pop = 1'b0;
  logic [7:0] req_ndesc = '0, req_ring = '0, req_code = '0, req_sector = '0;
  logic [31:0] req_tstamp = '0;
  logic [4:0] req_mcs = '0, req_qid = '0, req_nmsdu = '0;
  logic [11:0] req_seq = '0;
  logic req_ready, cons_new;
  logic [127:0] cons_entry;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_ring_writer #(.ORDER(ORD)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_ndesc(req_ndesc), .req_ring(req_ring), .req_code(req_code),
    .req_tstamp(req_tstamp), .req_mcs(req_mcs), .req_qid(req_qid),
    .req_nmsdu(req_nmsdu), .req_retry(req_retry), .req_sector(req_sector),
    .req_seq(req_seq), .cons_pop(cons_pop), .cons_new(cons_new),
    .cons_entry(cons_entry)
  );

  int checks = 0, failures = 0;
  logic [127:0] q[$];
  int hp = 0;
  bit wp = 1'b1;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    q.delete();
    hp = 0;
    wp = 1'b1;
  endtask

  task automatic compare();
    bit en, er;
    en = (q.size() > 0);
    er = (q.size() < N - 1);
    chk(req_ready === er, "R6 req_ready", 128'(req_ready), 128'(er));
    chk(cons_new === en, "R8 cons_new", 128'(cons_new), 128'(en));
    if (en) begin
      chk(cons_entry[30:0] === q[0][30:0], "R1 word0 fields", 128'(cons_entry[30:0]), 128'(q[0][30:0]));
      chk(cons_entry[31] === q[0][31], "R5 phase flag", 128'(cons_entry[31]), 128'(q[0][31]));
      chk(cons_entry[127:32] === q[0][127:32], "R2 R7 R10 words1-3", 128'(cons_entry[127:32]), 128'(q[0][127:32]));
    end
  endtask

  task automatic step(input bit v, input bit rsv, input bit p);
    bit en, er;
    logic [127:0] e;
    @(negedge clk);
    compare();
    en = (q.size() > 0);
    er = (q.size() < N - 1);
    req_valid  = v;
    req_ndesc  = 8'($urandom);
    req_ring   = 8'($urandom);
    req_code   = rsv ? 8'(4 + $urandom % 252) : 8'($urandom % 4);
    req_tstamp = $urandom;
    req_mcs    = 5'($urandom);
    req_qid    = 5'($urandom);
    req_nmsdu  = 5'($urandom);
    req_retry  = 1'($urandom);
    req_sector = 8'($urandom);
    req_seq    = 12'($urandom);
    cons_pop   = p;
    if (v && er && !rsv) begin
      e = '0;
      e[7:0] = req_ndesc; e[15:8] = req_ring; e[23:16] = req_code; e[31] = wp;
      e[63:32] = req_tstamp;
      e[68:64] = req_mcs; e[76:72] = req_qid; e[84:80] = req_nmsdu;
      e[87] = req_retry; e[95:88] = req_sector;
      e[107:96] = req_seq;
      q.push_back(e);
      hp = (hp + 1) % N;
      if (hp == 0) wp = ~wp;
    end
    if (p && en) void'(q.pop_front());
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    cons_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    chk(req_ready === 1'b1, "R4 ready after reset", 128'(req_ready), 128'(1));
    chk(cons_new === 1'b0, "R9 no new entry after reset", 128'(cons_new), 128'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R3: reserved code then short burst, drained
    step(1, 1, 0);
    step(1, 0, 0);
    step(1, 0, 0);
    step(1, 1, 0);
    step(1, 0, 0);
    repeat (5) step(0, 0, 1);
    // R8: pops on an empty ring are ignored
    repeat (3) step(0, 0, 1);
    // R6: fill to the stall point
    repeat (12) step(1, 0, 0);
    repeat (N) step(0, 0, 1);
    // R5 R10: mixed traffic across many wraps
    for (int i = 0; i < 600; i++)
      step(($urandom % 4) != 0, ($urandom % 8) == 0, ($urandom % 3) != 0);
    // R4 R9: reset with live entries
    repeat (4) step(1, 0, 0);
    do_reset();
    for (int i = 0; i < 200; i++)
      step(($urandom % 2) == 0, ($urandom % 10) == 0, ($urandom % 2) == 0);
    repeat (N + 2) step(0, 0, 1);
    step(0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule